// File: doc/BRIEF.md
# Fixed-Priority Chained Bus Arbiter

This block decides which of several potential bus masters may drive a shared bus. Every master has its own request line. The block ORs these lines into one shared request indication. While the bus is free, a grant token enters a chain of stages at device 0. Each stage either keeps the token, if its device is requesting, or hands it to the next stage. The device that keeps the token becomes the bus owner.

Ownership has no time limit. It ends only when the owning device pulses its release line. After that the bus is free for one clock, and the chain is evaluated again from device 0. Position in the chain alone sets the order. There is no rotation, so a device near the end of the chain can be locked out for as long as devices ahead of it keep requesting.

Devices are numbered 0 to N-1. Bit i of every per-device vector belongs to device i, and device 0 has the highest priority.

Top module: `daisy_arbiter`

## Requirements
- R1: During and after reset, with no request seen yet, `gnt_o` is all zero and `busy_o` is 0.
- R2: `bus_req_o` is the logical OR of all bits of `req_i` in the same cycle, whatever the bus state.
- R3: At a clock edge where `busy_o` is 0 and at least one `req_i` bit is 1, the grant goes to the lowest-numbered requesting device: bit i of `gnt_o` is set and `busy_o` is 1 from that edge on.
- R4: At most one bit of `gnt_o` is 1 at any time.
- R5: While the bus is owned, `gnt_o` does not change unless the owner releases. This holds even if the owner drops its request or a higher-priority device starts requesting.
- R6: When the owner asserts its own `rel_i` bit, `gnt_o` becomes zero and `busy_o` becomes 0 at the next edge. A new grant can be issued no earlier than the edge after that.
- R7: A `rel_i` bit from a device that does not own the bus has no effect on `gnt_o`, `busy_o` or `owner_o`.
- R8: While `busy_o` is 1, `owner_o` holds the binary index i of the device whose `gnt_o` bit is set.
- R9: A higher-priority device that requests again after each release wins every arbitration against a lower-priority device that requests at the same time.
- R10: A `gnt_o` bit rises only for a device whose `req_i` bit was 1 in the cycle before the edge. No request means no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MASTERS | Request from each device; bit i is device i |
| rel_i | input | N_MASTERS | Release pulse from each device |
| bus_req_o | output | 1 | OR of all requests (the shared request line) |
| gnt_o | output | N_MASTERS | Grant to each device, at most one bit set |
| busy_o | output | 1 | The bus is owned |
| owner_o | output | IDX_W | Index of the owning device, valid while busy_o is 1 |

## Verification
Two results are due at different times. The shared request line follows `req_i` in the same cycle, so it is checked shortly after inputs change. The grant, busy flag and owner index change only at the first rising edge after the stimulus. The driver applies each stimulus on a falling edge and queues the state expected after the next rising edge. The monitor pops that entry a quarter period after the rising edge and compares it. Each expected value is therefore checked exactly one register stage after its stimulus, and a release followed by a new request takes two queued steps: first the bus goes idle, then the new grant appears.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    ARB_FREE  = 1'b0,
    ARB_OWNED = 1'b1
  } arb_state_e;
endpackage

// File: rtl/arb_req_merge.sv
module arb_req_merge #(
  parameter int N_MASTERS = 4
) (
  input  logic [N_MASTERS-1:0] req_i,
  output logic                 any_req_o
);
  assign any_req_o = |req_i;
endmodule

// File: rtl/arb_grant_chain.sv
module arb_grant_chain #(
  parameter int N_MASTERS = 4
) (
  input  logic                 chain_in_i,
  input  logic [N_MASTERS-1:0] req_i,
  output logic [N_MASTERS-1:0] take_o,
  output logic                 pass_out_o
);
  logic [N_MASTERS:0] pass;

  assign pass[0] = chain_in_i;

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_stage
    // stage keeps the token when requesting, otherwise forwards it
    assign take_o[g]  = pass[g] & req_i[g];
    assign pass[g+1]  = pass[g] & ~req_i[g];
  end

  assign pass_out_o = pass[N_MASTERS];
endmodule

// File: rtl/arb_owner_ctrl.sv
module arb_owner_ctrl
  import arb_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [N_MASTERS-1:0] take_i,
  input  logic [N_MASTERS-1:0] rel_i,
  output logic                 free_o,
  output logic [N_MASTERS-1:0] gnt_o,
  output logic                 busy_o,
  output logic [IDX_W-1:0]     owner_o
);
  arb_state_e             state_q, state_d;
  logic [N_MASTERS-1:0]   gnt_q, gnt_d;
  logic [IDX_W-1:0]       idx_q, idx_d;
  logic                   owner_rel;

  assign owner_rel = |(rel_i & gnt_q);

  always_comb begin
    idx_d = idx_q;
    for (int i = N_MASTERS - 1; i >= 0; i--) begin
      if (take_i[i]) idx_d = IDX_W'(i);
    end
  end

  always_comb begin
    state_d = state_q;
    gnt_d   = gnt_q;
    unique case (state_q)
      ARB_FREE: begin
        if (start_i) begin
          state_d = ARB_OWNED;
          gnt_d   = take_i;
        end
      end
      ARB_OWNED: begin
        // only the owner's release frees the bus
        if (owner_rel) begin
          state_d = ARB_FREE;
          gnt_d   = '0;
        end
      end
      default: begin
        state_d = ARB_FREE;
        gnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARB_FREE;
      gnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      gnt_q   <= gnt_d;
      if (state_q == ARB_FREE && start_i) idx_q <= idx_d;
    end
  end

  assign free_o  = (state_q == ARB_FREE);
  assign gnt_o   = gnt_q;
  assign busy_o  = (state_q == ARB_OWNED);
  assign owner_o = idx_q;
endmodule

// File: rtl/daisy_arbiter.sv
module daisy_arbiter #(
  parameter int N_MASTERS = 4,
  localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic [N_MASTERS-1:0] rel_i,
  output logic                 bus_req_o,
  output logic [N_MASTERS-1:0] gnt_o,
  output logic                 busy_o,
  output logic [IDX_W-1:0]     owner_o
);
  logic                 free;
  logic [N_MASTERS-1:0] take;
  logic                 pass_out;
  logic                 start;

  arb_req_merge #(.N_MASTERS(N_MASTERS)) u_merge (
    .req_i     (req_i),
    .any_req_o (bus_req_o)
  );

  arb_grant_chain #(.N_MASTERS(N_MASTERS)) u_chain (
    .chain_in_i (free),
    .req_i      (req_i),
    .take_o     (take),
    .pass_out_o (pass_out)
  );

  // token was absorbed somewhere along the chain
  assign start = free & ~pass_out;

  arb_owner_ctrl #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .take_i  (take),
    .rel_i   (rel_i),
    .free_o  (free),
    .gnt_o   (gnt_o),
    .busy_o  (busy_o),
    .owner_o (owner_o)
  );
endmodule

// File: rtl/daisy_arbiter_checker.sv
module daisy_arbiter_checker #(
  parameter int N_MASTERS = 4,
  parameter int IDX_W     = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [N_MASTERS-1:0] req_i,
  input logic [N_MASTERS-1:0] rel_i,
  input logic                 bus_req_o,
  input logic [N_MASTERS-1:0] gnt_o,
  input logic                 busy_o,
  input logic [IDX_W-1:0]     owner_o
);
  p_reset_idle_r1: assert property (@(posedge clk_i) !rst_ni |-> (gnt_o == '0 && !busy_o));

  p_shared_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o == (req_i != '0));

  p_free_grants_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i != '0) |=> busy_o);

  p_single_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (rel_i & gnt_o) == '0) |=> $stable(gnt_o) && busy_o);

  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (rel_i & gnt_o) != '0) |=> (gnt_o == '0 && !busy_o));

  p_owner_idx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> gnt_o[owner_o]);

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_bit
    p_grant_needs_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gnt_o[g]) |-> $past(req_i[g]));
  end
endmodule

bind daisy_arbiter daisy_arbiter_checker #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .rel_i     (rel_i),
  .bus_req_o (bus_req_o),
  .gnt_o     (gnt_o),
  .busy_o    (busy_o),
  .owner_o   (owner_o)
);

// File: tb/daisy_arbiter_bench.sv
`timescale 1ns/1ps
module daisy_arbiter_bench;
  localparam int N = 4;
  localparam int W = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] rel = '0;
  logic         bus_req;
  logic [N-1:0] gnt;
  logic         busy;
  logic [W-1:0] owner;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [N-1:0] gnt;
    logic         busy;
    logic [W-1:0] owner;
    string        tag;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  daisy_arbiter #(.N_MASTERS(N)) u_daisy_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rel_i(rel),
    .bus_req_o(bus_req), .gnt_o(gnt), .busy_o(busy), .owner_o(owner)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // apply stimulus on falling edge, queue state expected after next rising edge
  task automatic step(input logic [N-1:0] r, input logic [N-1:0] l,
                      input logic [N-1:0] eg, input logic eb, input logic [W-1:0] eo,
                      input string tag);
    exp_t e;
    @(negedge clk);
    req = r;
    rel = l;
    e.gnt = eg; e.busy = eb; e.owner = eo; e.tag = tag;
    sb.push_back(e);
    #1;
    chk(bus_req == (r != '0), "R2 shared request", int'(bus_req), int'(r != '0));
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(gnt == e.gnt, {e.tag, " gnt"}, int'(gnt), int'(e.gnt));
        chk(busy == e.busy, {e.tag, " busy"}, int'(busy), int'(e.busy));
        chk($countones(gnt) <= 1, "R4 single grant", $countones(gnt), 1);
        if (e.busy) chk(owner == e.owner, {e.tag, " owner R8"}, int'(owner), int'(e.owner));
      end
    end
  end

  // watchdog
  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #35;
    chk(gnt == '0 && !busy, "R1 reset state", int'(gnt), 0);
    @(negedge clk);
    rst_n = 1'b1;
    chk(gnt == '0 && !busy, "R1 after reset", int'(gnt), 0);

    step(4'b1010, 4'b0000, 4'b0010, 1, 2'd1, "R3 lowest requester");
    step(4'b1011, 4'b0000, 4'b0010, 1, 2'd1, "R5 no preempt");
    step(4'b1011, 4'b1000, 4'b0010, 1, 2'd1, "R7 foreign release");
    step(4'b1001, 4'b0010, 4'b0000, 0, 2'd0, "R6 owner release");
    step(4'b1001, 4'b0000, 4'b0001, 1, 2'd0, "R3 rearbitrate");
    step(4'b1001, 4'b0001, 4'b0000, 0, 2'd0, "R6 release dev0");
    step(4'b1001, 4'b0000, 4'b0001, 1, 2'd0, "R9 starvation");
    step(4'b1000, 4'b0001, 4'b0000, 0, 2'd0, "R6 release dev0 again");
    step(4'b1000, 4'b0000, 4'b1000, 1, 2'd3, "R3 last device");
    step(4'b0000, 4'b0000, 4'b1000, 1, 2'd3, "R5 hold without request");
    step(4'b0000, 4'b1000, 4'b0000, 0, 2'd0, "R6 release dev3");
    step(4'b0000, 4'b0000, 4'b0000, 0, 2'd0, "R10 no request no grant");
    step(4'b0100, 4'b0100, 4'b0100, 1, 2'd2, "R7 release while free");
    step(4'b0000, 4'b0100, 4'b0000, 0, 2'd0, "R6 release dev2");

    @(negedge clk);
    @(negedge clk);
    chk(sb.size() == 0, "scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule